// File: doc/BRIEF.md
# Floor-Free Deinterleaver Address Generator

This block produces the memory write addresses for a two-dimensional channel deinterleaver of a mobile broadband OFDM receiver. It supports three bit loadings per carrier: 2, 4 and 6 bits. For each loading it supports every coded block length. The deinterleaver is 16 rows deep. For each received bit index j, the block gives the address where that bit must be stored so that a plain sequential read returns the bits in their original order. It also provides that sequential read address.

The usual inverse permutation uses integer division and floor operations. Here no divider, floor operator or lookup table appears. A row counter, a column-group counter and a position-in-group counter are nested, and the comparator on the column counter sets its terminal count. A small modulo-add rotates the position inside each bit group by the row number modulo the group size. A multiply-add then combines the permuted column with the row. The selects are sampled only when a block starts. While enable is high, the block gives one address per cycle. Blocks follow one another with no gap.

The control is a two-state machine. In `S_IDLE` the block sits at a block boundary with all counters at zero. In `S_RUN` it is inside a block. Transition T_START (`S_IDLE` to `S_RUN`) happens when enable is high at a boundary, and it latches the selects. T_PAUSE is the `S_RUN` self-loop taken while enable is low. T_FINISH (`S_RUN` to `S_IDLE`) happens on the last address of a block.

Top module: `deintl_addr_gen`

## Requirements
- R1: After synchronous reset, while `en_i` stays low, `addr_vld_o` and `blk_end_o` are 0 and both `wr_addr_o` and `rd_addr_o` are 0.
- R2: `mod_sel_i` code 0 selects s=1 (2 bits per carrier), code 1 selects s=2 and code 2 selects s=3. `size_sel_i` code c in 0..5 selects m=c+1. The block length is N = 96·m·s and C = N/16.
- R3: With s=1, the address for bit j equals k = 16·mj − (N−1)·floor(16·mj/N), where mj = s·floor(j/s) + (j + floor(16·j/N)) mod s.
- R4: With s=2, the address follows the formula of R3, so the two positions of each bit pair swap on odd rows.
- R5: With s=3, the address follows the formula of R3, so the three positions of each bit triple rotate by the row number modulo 3.
- R6: `rd_addr_o` equals j, the index of the current bit within the block. It counts 0 to N−1 and then wraps.
- R7: `blk_end_o` is high in the same cycle as the address for j=N−1. In the next enabled cycle j=0 is produced, with no idle cycle between blocks.
- R8: The selects are sampled only in the cycle that starts a block. A change during a block takes effect at the next block.
- R9: `addr_vld_o` equals `en_i`. While `en_i` is low the block does not advance, `blk_end_o` is 0, and both addresses hold the pending bit's values.
- R10: `mod_sel_i` code 3 acts as code 2, and `size_sel_i` codes 6 and 7 act as code 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance one bit this cycle |
| mod_sel_i | input | 2 | Bit-loading select, sampled at block start |
| size_sel_i | input | 3 | Block-length select, sampled at block start |
| wr_addr_o | output | 11 | Deinterleaver write address for the current bit |
| rd_addr_o | output | 11 | Sequential read address |
| addr_vld_o | output | 1 | Addresses valid this cycle |
| blk_end_o | output | 1 | Last bit of the block |

## Verification
The bench runs every loading and block-length pair back to back. It compares each address against a floor-based formula. A wrong group rotation would show up as swapped addresses on odd rows for s=2, or as a wrong triple order for s=3. A terminal count that ignored the block length would wrap the column counter at the wrong place and fire the end pulse early or late. The bench also changes the selects during a block; a design that sampled them live would change its address pattern mid-block. It drops enable during a block; a design that kept counting would skip addresses when enable returned. It drives out-of-range codes; a design without saturation would produce a length or group size that does not exist.

// File: rtl/deintl_pkg.sv
package deintl_pkg;

    // Control states of the block sequencer
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,   // at a block boundary, counters at zero
        S_RUN  = 1'b1    // inside a block
    } blk_state_e;

    // Bit-loading select codes
    typedef enum logic [1:0] {
        MOD_B2   = 2'd0,
        MOD_B4   = 2'd1,
        MOD_B6   = 2'd2,
        MOD_RSVD = 2'd3
    } mod_code_e;

    // Group size s (bits per carrier / 2) for a loading code; reserved saturates
    function automatic logic [1:0] group_size(input logic [1:0] code);
        logic [1:0] s;
        unique case (code)
            MOD_B2:  s = 2'd1;
            MOD_B4:  s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/deintl_cfg_decode.sv
module deintl_cfg_decode #(
    parameter int ROWS      = 16,
    parameter int UNIT      = 96,
    parameter int MAX_SUBCH = 6,
    parameter int SW        = 3,
    parameter int CW        = 7,
    parameter int AW        = 11
) (
    input  logic [1:0]    mod_i,
    input  logic [SW-1:0] size_i,
    output logic [1:0]    bps_o,
    output logic [CW-1:0] col_last_o,
    output logic [AW-1:0] blk_last_o
);
    import deintl_pkg::*;

    localparam int COLS_PER_UNIT = UNIT / ROWS;

    int unsigned m_v;
    int unsigned s_v;
    int unsigned cols_v;
    int unsigned len_v;

    always_comb begin
        bps_o = group_size(mod_i);
        s_v   = int'(bps_o);
        // saturate the size code to the largest legal block
        if (int'(size_i) >= MAX_SUBCH - 1) m_v = MAX_SUBCH;
        else                               m_v = int'(size_i) + 1;
        cols_v     = COLS_PER_UNIT * m_v * s_v;
        len_v      = UNIT * m_v * s_v;
        col_last_o = CW'(cols_v - 1);
        blk_last_o = AW'(len_v - 1);
    end

endmodule

// File: rtl/deintl_wr_core.sv
module deintl_wr_core #(
    parameter int ROWS = 16,
    parameter int CW   = 7,
    parameter int AW   = 11,
    parameter int RW   = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          step_i,
    input  logic [1:0]    bps_i,
    input  logic [CW-1:0] col_last_i,
    output logic [AW-1:0] wr_addr_o,
    output logic          blk_last_o
);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

    logic [RW-1:0] row_q;    // row number, 0..ROWS-1
    logic [CW-1:0] base_q;   // first column of the current bit group
    logic [1:0]    pos_q;    // position inside the group, 0..s-1
    logic [1:0]    rot_q;    // row number modulo s

    logic          grp_end;
    logic          col_end;
    logic          row_end;
    logic [2:0]    pos_sum;
    logic [1:0]    pos_perm;
    logic [CW-1:0] col_perm;

    always_comb begin
        grp_end  = (pos_q == (bps_i - 2'd1));
        col_end  = grp_end && ((base_q + CW'(pos_q)) == col_last_i);
        row_end  = (row_q == ROW_LAST);
        // modulo-s add of position and row rotation (incrementer / decrementer pair)
        pos_sum  = {1'b0, pos_q} + {1'b0, rot_q};
        if (pos_sum >= {1'b0, bps_i}) pos_perm = 2'(pos_sum - {1'b0, bps_i});
        else                          pos_perm = pos_sum[1:0];
        col_perm   = base_q + CW'(pos_perm);
        wr_addr_o  = AW'(AW'(col_perm) * AW'(ROWS)) + AW'(row_q);
        blk_last_o = col_end && row_end;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            row_q  <= '0;
            base_q <= '0;
            pos_q  <= '0;
            rot_q  <= '0;
        end else if (step_i) begin
            if (grp_end) begin
                pos_q <= '0;
                if (col_end) begin
                    base_q <= '0;
                    if (row_end) begin
                        row_q <= '0;
                        rot_q <= '0;
                    end else begin
                        row_q <= row_q + RW'(1);
                        rot_q <= (rot_q == (bps_i - 2'd1)) ? 2'd0 : rot_q + 2'd1;
                    end
                end else begin
                    base_q <= base_q + CW'(bps_i);
                end
            end else begin
                pos_q <= pos_q + 2'd1;
            end
        end
    end

    AST_POS_IN_GROUP: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q < bps_i);                                             // R4
    AST_ROT_IN_GROUP: assert property (@(posedge clk_i) disable iff (rst_i)
        rot_q < bps_i);                                             // R5
    AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (base_q + CW'(pos_q)) <= col_last_i);                        // R3

endmodule

// File: rtl/deintl_rd_cnt.sv
module deintl_rd_cnt #(
    parameter int AW = 11
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          step_i,
    input  logic          last_i,
    output logic [AW-1:0] rd_addr_o
);
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (step_i) cnt_q <= last_i ? '0 : cnt_q + AW'(1);
    end

    assign rd_addr_o = cnt_q;

endmodule

// File: rtl/deintl_addr_gen.sv
module deintl_addr_gen #(
    parameter int ROWS      = 16,
    parameter int UNIT      = 96,
    parameter int MAX_SUBCH = 6,
    parameter int MAX_S     = 3,
    parameter int SW        = 3,
    localparam int MAX_COLS = (UNIT / ROWS) * MAX_SUBCH * MAX_S,
    localparam int MAX_LEN  = UNIT * MAX_SUBCH * MAX_S,
    localparam int CW       = $clog2(MAX_COLS),
    localparam int AW       = $clog2(MAX_LEN),
    localparam int RW       = $clog2(ROWS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [1:0]    mod_sel_i,
    input  logic [SW-1:0] size_sel_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          addr_vld_o,
    output logic          blk_end_o
);
    import deintl_pkg::*;

    blk_state_e    state_q, state_d;
    logic [1:0]    mod_q;
    logic [SW-1:0] size_q;
    logic          at_start;
    logic [1:0]    mod_eff;
    logic [SW-1:0] size_eff;
    logic [1:0]    bps;
    logic [CW-1:0] col_last;
    logic [AW-1:0] blk_last_idx;
    logic          blk_last;

    // selects are live only at a block boundary, latched otherwise
    always_comb begin
        at_start = (state_q == S_IDLE);
        mod_eff  = at_start ? mod_sel_i  : mod_q;
        size_eff = at_start ? size_sel_i : size_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mod_q  <= '0;
            size_q <= '0;
        end else if (at_start && en_i) begin
            mod_q  <= mod_sel_i;
            size_q <= size_sel_i;
        end
    end

    deintl_cfg_decode #(
        .ROWS(ROWS), .UNIT(UNIT), .MAX_SUBCH(MAX_SUBCH),
        .SW(SW), .CW(CW), .AW(AW)
    ) cfg_i (
        .mod_i      (mod_eff),
        .size_i     (size_eff),
        .bps_o      (bps),
        .col_last_o (col_last),
        .blk_last_o (blk_last_idx)
    );

    deintl_wr_core #(
        .ROWS(ROWS), .CW(CW), .AW(AW), .RW(RW)
    ) wr_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .step_i     (en_i),
        .bps_i      (bps),
        .col_last_i (col_last),
        .wr_addr_o  (wr_addr_o),
        .blk_last_o (blk_last)
    );

    deintl_rd_cnt #(.AW(AW)) rd_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .step_i    (en_i),
        .last_i    (blk_last),
        .rd_addr_o (rd_addr_o)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_IDLE;
        else       state_q <= state_d;
    end

    // next state: T_START, T_PAUSE, T_FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (en_i)             state_d = S_RUN;
            S_RUN:  if (en_i && blk_last) state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        addr_vld_o = en_i;
        blk_end_o  = en_i && blk_last;
    end

    AST_END_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        blk_end_o |=> (rd_addr_o == '0) && (wr_addr_o == '0));       // R7
    AST_RD_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !blk_end_o) |=> (rd_addr_o == $past(rd_addr_o) + AW'(1))); // R6
    AST_HOLD_PAUSED: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(rd_addr_o) && $stable(wr_addr_o)));       // R9
    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_RUN && $past(state_q) == S_RUN) |-> ($stable(mod_q) && $stable(size_q))); // R8
    AST_ADDR_IN_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |-> (wr_addr_o <= blk_last_idx && rd_addr_o <= blk_last_idx)); // R2

endmodule

// File: tb/deintl_addr_gen_tb_top.sv
`timescale 1ns/1ps
module deintl_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [1:0]  mod_sel;
    logic [2:0]  size_sel;
    logic [10:0] wr_addr;
    logic [10:0] rd_addr;
    logic        vld;
    logic        blk_end;

    int errors = 0;
    int checks = 0;
    int j      = 0;     // model bit index
    int ms     = 1;     // model group size of current block
    int mn     = 96;    // model block length of current block
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    deintl_addr_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .en_i       (en),
        .mod_sel_i  (mod_sel),
        .size_sel_i (size_sel),
        .wr_addr_o  (wr_addr),
        .rd_addr_o  (rd_addr),
        .addr_vld_o (vld),
        .blk_end_o  (blk_end)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (j=%0d)", tag, act, exp, j);
        end
    endtask

    // floor-based inverse permutation (R3, R4, R5)
    function automatic int ref_addr(input int jj, input int s, input int n);
        int a, mj;
        a  = (16 * jj) / n;
        mj = s * (jj / s) + ((jj + a) % s);
        return 16 * mj - (n - 1) * ((16 * mj) / n);
    endfunction

    // one clock: drive after the falling edge, check before the rising edge
    task automatic run_cycle(input logic e, input logic [1:0] md, input logic [2:0] sz,
                             input string tg);
        int m, exp_wr;
        string wtag;
        @(negedge clk);
        en = e; mod_sel = md; size_sel = sz;
        #5;
        if (e && j == 0) begin
            ms = (md == 2'd0) ? 1 : (md == 2'd1) ? 2 : 3;   // R2, R10
            m  = (sz >= 3'd5) ? 6 : int'(sz) + 1;
            mn = 96 * m * ms;
        end
        exp_wr = ref_addr(j, ms, mn);
        if (tg != "")     wtag = tg;
        else if (ms == 1) wtag = "R3";
        else if (ms == 2) wtag = "R4";
        else              wtag = "R5";
        check("R9 valid", int'(vld), int'(e));
        check("R2 R7 end", int'(blk_end), int'(e && (j == mn - 1)));
        check("R6 rd", int'(rd_addr), j);
        check(wtag, int'(wr_addr), exp_wr);
        if (e) j = (j == mn - 1) ? 0 : j + 1;
    endtask

    task automatic run_block(input logic [1:0] md, input logic [2:0] sz, input string tg);
        int m, n;
        m = (sz >= 3'd5) ? 6 : int'(sz) + 1;
        n = 96 * m * ((md == 2'd0) ? 1 : (md == 2'd1) ? 2 : 3);
        for (int i = 0; i < n; i++) run_cycle(1'b1, md, sz, tg);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; mod_sel = '0; size_sel = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: reset state with enable low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #5;
            check("R1 valid", int'(vld), 0);
            check("R1 end", int'(blk_end), 0);
            check("R1 wr", int'(wr_addr), 0);
            check("R1 rd", int'(rd_addr), 0);
        end
        // all legal loadings and lengths, back to back (R3 R4 R5 R7)
        for (int md = 0; md < 3; md++)
            for (int sz = 0; sz < 6; sz++)
                run_block(2'(md), 3'(sz), "");
        // R9: pause in the middle of a block
        for (int i = 0; i < 100; i++) run_cycle(1'b1, 2'd1, 3'd2, "");
        for (int i = 0; i < 4; i++)   run_cycle(1'b0, 2'd1, 3'd2, "R9");
        for (int i = 100; i < 576; i++) run_cycle(1'b1, 2'd1, 3'd2, "");
        // R8: selects change mid-block, old setting must persist
        for (int i = 0; i < 40; i++)  run_cycle(1'b1, 2'd0, 3'd0, "");
        for (int i = 40; i < 96; i++) run_cycle(1'b1, 2'd3, 3'd7, "R8");
        // R10: reserved codes saturate for the next block
        run_block(2'd3, 3'd7, "R10");
        for (int i = 0; i < 3; i++) run_cycle(1'b0, 2'd0, 3'd0, "R9");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule